// File: doc/BRIEF.md
# One-Time-Programmable Array Programming Sequencer

This block sits on the programmer side of a one-time-programmable word array and carries a whole device through its programming flow without software help. After a start pulse it checks the socket contacts, programs every word with one timed pulse, verifies every word with a bounded number of extra pulses, then drops both supplies to the low read level and reads the whole array back. At the end it raises `done` and reports the result on `pass`.

The analog side is not part of the block. It emits 2-bit level codes for the core and programming supplies, a chip-enable, a three-level output-enable control, a word address and write data. It reads the device's data lines back and compares them with an `exp_data` input. The surrounding logic supplies `exp_data` for whatever address the block presents. Every wait is counted in ticks of a one-microsecond strobe. A `LAST_ADDR` parameter bounds the array so that a small range can be used.

Top module: `otp_prog_seq`

## Requirements
- R1: While `rst` is high and after it falls, the outputs read: `done`=0, `pass`=0, both supply codes 0 (off), `ce_n`=1, `oe_lvl`=1 (high), `data_drive`=0.
- R2: The run opens with both supply codes at 2 (4.0 V). With `ce_n`=0 and `oe_lvl`=2 (check level) the block presents address 0x0AAAA and expects data 0x5555, then presents 0x05555 and expects 0xAAAA. Any other read value, 0xFFFF included, ends the run with `pass`=0 before any program pulse is given.
- R3: With `vpp_sel`=3 (high) and `vcc_sel`=2, the block gives every address from 0 to `LAST_ADDR`, in rising order, exactly one pulse before any verify read. A pulse has `ce_n`=0 and `oe_lvl`=1, lasts `PULSE_TICKS` ticks, and carries `wr_data` equal to `exp_data` for that address.
- R4: While `vpp_sel`=3, the address changes only in a cycle with `ce_n`=1 and `oe_lvl`=1.
- R5: After any change of either supply code, at least `SETTLE_TICKS` ticks pass before `ce_n` falls.
- R6: A verify read has `vpp_sel`=3, `ce_n`=1 and `oe_lvl`=0. When it mismatches, the word gets one more pulse and is read again, up to `MAX_RETRY` extra pulses per word. A mismatch after the last allowed retry ends the run with `pass`=0.
- R7: After every word verifies, both supply codes go to 1 (3.0 V). Every word is read with `ce_n`=0 and `oe_lvl`=0. A mismatch gives `pass`=0, and a full match gives `pass`=1.
- R8: `done` and `pass` hold until the next `start`. `start` has no effect while a run is in progress. `start` while done clears `done` and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (idle or done only) |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| exp_data | input | 16 | Expected word for the presented address |
| rd_data | input | 16 | Data read back from the device |
| vcc_sel | output | 2 | Core supply code: 0 off, 1 3.0 V, 2 4.0 V |
| vpp_sel | output | 2 | Program supply code: 0 off, 1 3.0 V, 2 4.0 V, 3 9.75 V |
| ce_n | output | 1 | Chip enable, active low |
| oe_lvl | output | 2 | Output-enable level: 0 low, 1 high, 2 check level |
| addr | output | 21 | Word address |
| wr_data | output | 16 | Data driven during program pulses |
| data_drive | output | 1 | Programmer drives the data lines |
| done | output | 1 | Run finished |
| pass | output | 1 | Run result, valid with done |

## Verification
The bench models a device in which some words need two or three pulses, and it measures every pulse in ticks. A sequencer that interleaved verify with programming, mis-sized a pulse, or retried once too often or once too seldom would show up in the per-word pulse counts. Separate runs break the check-level readback, make one word need more pulses than the retry limit allows, and flip one word only at the low read supply. A block that skipped the contact check, the retry limit or the final read would then report pass. The bench also watches every address change and falling chip-enable against the supply codes, and it repeats `start` mid-run and after done to catch a restart that should not happen or a done flag that does not clear.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [1:0] {
    SUP_OFF  = 2'd0,
    SUP_3V0  = 2'd1,
    SUP_4V0  = 2'd2,
    SUP_HIGH = 2'd3
  } sup_lvl_e;

  typedef enum logic [1:0] {
    OE_LOW   = 2'd0,
    OE_HIGH  = 2'd1,
    OE_CHECK = 2'd2
  } oe_lvl_e;

  typedef enum logic [1:0] {
    AS_CNT   = 2'd0,
    AS_PAT_A = 2'd1,
    AS_PAT_B = 2'd2
  } addr_src_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CC_SET,
    ST_CC_A,
    ST_CC_B,
    ST_PG_SET,
    ST_PG_ADDR,
    ST_PG_PULSE,
    ST_PG_HOLD,
    ST_VF_ADDR,
    ST_VF_READ,
    ST_RD_SET,
    ST_RD_READ,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/otp_seq_timer.sv
module otp_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // Without a reload the remaining wait never grows (settle windows, R5)
  assert_timer_monotone_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/otp_seq_addr.sv
module otp_seq_addr #(
  parameter int ADDR_W    = 21,
  parameter int LAST_ADDR = 2097151
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] cnt,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(LAST_ADDR);

  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt_q <= '0;
    else if (inc && !at_last) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt     = cnt_q;
  assign at_last = (cnt_q == LAST_V);

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_V);
endmodule

// File: rtl/otp_seq_retry.sv
module otp_seq_retry #(
  parameter int MAX_RETRY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_max
);
  localparam int RW = $clog2(MAX_RETRY + 2);
  localparam logic [RW-1:0] MAX_V = RW'(MAX_RETRY);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)         cnt_q <= '0;
    else if (inc && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  assign at_max = (cnt_q == MAX_V);

  assert_retry_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= MAX_V);
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int ADDR_W       = 21,
  parameter int DATA_W       = 16,
  parameter int LAST_ADDR    = 2097151,
  parameter int SETTLE_TICKS = 3,
  parameter int PULSE_TICKS  = 10,
  parameter int SETUP_TICKS  = 1,
  parameter int RD_TICKS     = 1,
  parameter int MAX_RETRY    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              us_tick,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic [1:0]        vcc_sel,
  output logic [1:0]        vpp_sel,
  output logic              ce_n,
  output logic [1:0]        oe_lvl,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              data_drive,
  output logic              done,
  output logic              pass
);
  localparam int MAX_AB = (SETTLE_TICKS > PULSE_TICKS) ? SETTLE_TICKS : PULSE_TICKS;
  localparam int MAX_CD = (SETUP_TICKS > RD_TICKS) ? SETUP_TICKS : RD_TICKS;
  localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TW     = $clog2(MAX_T + 1);
  localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_TICKS);
  localparam logic [TW-1:0] T_PULSE  = TW'(PULSE_TICKS);
  localparam logic [TW-1:0] T_SETUP  = TW'(SETUP_TICKS);
  localparam logic [TW-1:0] T_RD     = TW'(RD_TICKS);
  localparam logic [DATA_W-1:0] PAT_A = {(DATA_W/2){2'b10}};
  localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;

  seq_st_e      st_q, st_d;
  logic [1:0]   vcc_q, vcc_d, vpp_q, vpp_d, oe_q, oe_d, asrc_q, asrc_d;
  logic         ce_n_q, ce_d, drv_q, drv_d, done_q, done_d, pass_q, pass_d, vfy_q, vfy_d;
  logic [DATA_W-1:0] wr_q;

  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          a_clr, a_inc, a_last;
  logic [ADDR_W-1:0] a_cnt;
  logic          r_clr, r_inc, r_max;
  logic          fail_now, pass_now;

  otp_seq_timer #(.CNT_W(TW)) timer_i (
    .clk(clk), .rst(rst), .tick(us_tick), .load(t_load),
    .load_val(t_val), .expired(t_exp)
  );

  otp_seq_addr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) addr_i (
    .clk(clk), .rst(rst), .clr(a_clr), .inc(a_inc),
    .cnt(a_cnt), .at_last(a_last)
  );

  otp_seq_retry #(.MAX_RETRY(MAX_RETRY)) retry_i (
    .clk(clk), .rst(rst), .clr(r_clr), .inc(r_inc), .at_max(r_max)
  );

  always_comb begin
    st_d   = st_q;   vcc_d  = vcc_q;  vpp_d  = vpp_q;  ce_d   = ce_n_q;
    oe_d   = oe_q;   asrc_d = asrc_q; drv_d  = drv_q;  done_d = done_q;
    pass_d = pass_q; vfy_d  = vfy_q;
    t_load = 1'b0;   t_val  = '0;
    a_clr  = 1'b0;   a_inc  = 1'b0;   r_clr  = 1'b0;   r_inc  = 1'b0;
    fail_now = 1'b0; pass_now = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          st_d = ST_CC_SET; vcc_d = SUP_4V0; vpp_d = SUP_4V0;
          ce_d = 1'b1; oe_d = OE_HIGH; asrc_d = AS_CNT; drv_d = 1'b0;
          done_d = 1'b0; pass_d = 1'b0; vfy_d = 1'b0; a_clr = 1'b1;
          t_load = 1'b1; t_val = T_SETTLE;
        end
      end
      ST_CC_SET: if (t_exp) begin
        st_d = ST_CC_A; ce_d = 1'b0; oe_d = OE_CHECK; asrc_d = AS_PAT_A;
        t_load = 1'b1; t_val = T_RD;
      end
      ST_CC_A: if (t_exp) begin
        if (rd_data == ~PAT_A) begin
          st_d = ST_CC_B; asrc_d = AS_PAT_B; t_load = 1'b1; t_val = T_RD;
        end else fail_now = 1'b1;
      end
      ST_CC_B: if (t_exp) begin
        if (rd_data == ~PAT_B) begin
          st_d = ST_PG_SET; vpp_d = SUP_HIGH; ce_d = 1'b1; oe_d = OE_HIGH;
          asrc_d = AS_CNT; t_load = 1'b1; t_val = T_SETTLE;
        end else fail_now = 1'b1;
      end
      ST_PG_SET: if (t_exp) begin
        st_d = ST_PG_ADDR; drv_d = 1'b1; t_load = 1'b1; t_val = T_SETUP;
      end
      ST_PG_ADDR: if (t_exp) begin
        st_d = ST_PG_PULSE; ce_d = 1'b0; t_load = 1'b1; t_val = T_PULSE;
      end
      ST_PG_PULSE: if (t_exp) begin
        st_d = ST_PG_HOLD; ce_d = 1'b1; t_load = 1'b1; t_val = T_SETUP;
      end
      ST_PG_HOLD: if (t_exp) begin
        if (vfy_q) begin
          st_d = ST_VF_READ; oe_d = OE_LOW; drv_d = 1'b0;
          t_load = 1'b1; t_val = T_RD;
        end else if (a_last) begin
          st_d = ST_VF_ADDR; a_clr = 1'b1; r_clr = 1'b1; vfy_d = 1'b1;
          drv_d = 1'b0; t_load = 1'b1; t_val = T_SETUP;
        end else begin
          st_d = ST_PG_ADDR; a_inc = 1'b1; t_load = 1'b1; t_val = T_SETUP;
        end
      end
      ST_VF_ADDR: if (t_exp) begin
        st_d = ST_VF_READ; oe_d = OE_LOW; t_load = 1'b1; t_val = T_RD;
      end
      ST_VF_READ: if (t_exp) begin
        oe_d = OE_HIGH;
        if (rd_data == exp_data) begin
          if (a_last) begin
            st_d = ST_RD_SET; vcc_d = SUP_3V0; vpp_d = SUP_3V0; a_clr = 1'b1;
            t_load = 1'b1; t_val = T_SETTLE;
          end else begin
            st_d = ST_VF_ADDR; a_inc = 1'b1; r_clr = 1'b1;
            t_load = 1'b1; t_val = T_SETUP;
          end
        end else if (r_max) begin
          fail_now = 1'b1;
        end else begin
          st_d = ST_PG_ADDR; r_inc = 1'b1; drv_d = 1'b1;
          t_load = 1'b1; t_val = T_SETUP;
        end
      end
      ST_RD_SET: if (t_exp) begin
        st_d = ST_RD_READ; ce_d = 1'b0; oe_d = OE_LOW; t_load = 1'b1; t_val = T_RD;
      end
      ST_RD_READ: if (t_exp) begin
        if (rd_data != exp_data) fail_now = 1'b1;
        else if (a_last)         pass_now = 1'b1;
        else begin
          a_inc = 1'b1; t_load = 1'b1; t_val = T_RD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (fail_now || pass_now) begin
      st_d = ST_DONE; vcc_d = SUP_OFF; vpp_d = SUP_OFF; ce_d = 1'b1;
      oe_d = OE_HIGH; asrc_d = AS_CNT; drv_d = 1'b0;
      done_d = 1'b1; pass_d = pass_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE; vcc_q <= SUP_OFF; vpp_q <= SUP_OFF; ce_n_q <= 1'b1;
      oe_q   <= OE_HIGH; asrc_q <= AS_CNT; drv_q <= 1'b0; done_q <= 1'b0;
      pass_q <= 1'b0;    vfy_q <= 1'b0;   wr_q  <= '0;
    end else begin
      st_q   <= st_d;   vcc_q  <= vcc_d;  vpp_q <= vpp_d; ce_n_q <= ce_d;
      oe_q   <= oe_d;   asrc_q <= asrc_d; drv_q <= drv_d; done_q <= done_d;
      pass_q <= pass_d; vfy_q  <= vfy_d;
      if (st_q == ST_PG_ADDR) wr_q <= exp_data;
    end
  end

  assign vcc_sel    = vcc_q;
  assign vpp_sel    = vpp_q;
  assign ce_n       = ce_n_q;
  assign oe_lvl     = oe_q;
  assign wr_data    = wr_q;
  assign data_drive = drv_q;
  assign done       = done_q;
  assign pass       = pass_q;
  assign addr       = (asrc_q == AS_PAT_A) ? ADDR_W'(PAT_A) :
                      (asrc_q == AS_PAT_B) ? ADDR_W'(PAT_B) : a_cnt;

  assert_check_level_R2: assert property (@(posedge clk) disable iff (rst)
    (oe_q == OE_CHECK) |-> (vcc_q == SUP_4V0 && vpp_q == SUP_4V0 && !ce_n_q));

  assert_pulse_supply_R3: assert property (@(posedge clk) disable iff (rst)
    (!ce_n_q && oe_q == OE_HIGH) |-> (vpp_q == SUP_HIGH && vcc_q == SUP_4V0));

  assert_addr_inhibit_R4: assert property (@(posedge clk) disable iff (rst)
    (vpp_q == SUP_HIGH && addr != $past(addr)) |-> (ce_n_q && oe_q == OE_HIGH));

  assert_read_low_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RD_READ) |-> (vcc_q == SUP_3V0 && vpp_q == SUP_3V0));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> (done_q && $stable(pass_q)));
endmodule

// File: tb/otp_prog_seq_tb_top.sv
module otp_prog_seq_tb_top;
  localparam int N      = 16;
  localparam int DIV    = 4;
  localparam int SETTLE = 3;
  localparam int PULSE  = 10;
  localparam int RETRY  = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, us_tick = 1'b0;
  logic [15:0] exp_data, rd_data, wr_data;
  logic [1:0]  vcc_sel, vpp_sel, oe_lvl;
  logic        ce_n, data_drive, done, pass;
  logic [20:0] addr;

  always #5 clk = ~clk;

  otp_prog_seq #(.LAST_ADDR(N-1), .SETTLE_TICKS(SETTLE), .PULSE_TICKS(PULSE),
                 .SETUP_TICKS(1), .RD_TICKS(1), .MAX_RETRY(RETRY)) dut_i (
    .clk(clk), .rst(rst), .start(start), .us_tick(us_tick),
    .exp_data(exp_data), .rd_data(rd_data), .vcc_sel(vcc_sel), .vpp_sel(vpp_sel),
    .ce_n(ce_n), .oe_lvl(oe_lvl), .addr(addr), .wr_data(wr_data),
    .data_drive(data_drive), .done(done), .pass(pass));

  int checks = 0, errs = 0;
  int div = 0, tick_total = 0;
  logic [15:0] mem [N];
  int pcnt [N];
  int weak_a, weak_n, bad_rd, total_pulses, pulses_before_vf;
  int width_err, wd_err, order_err, settle_err, inh_err, pulse_start, pulse_addr, sup_tick;
  bit cc_fault, seen_vf, rd3_seen, cc_a_seen, cc_b_seen, pulse_prev, ce_prev;
  logic [1:0] vcc_prev, vpp_prev;
  logic [20:0] addr_prev;

  function automatic logic [15:0] word_of(input int a);
    return 16'((a * 32'h1357) ^ 32'hA5C3);
  endfunction

  function automatic int need_of(input int a);
    if (a == 3) return 2;
    if (a == weak_a) return weak_n;
    return 1;
  endfunction

  assign exp_data = word_of(int'(addr));

  always_comb begin
    if (oe_lvl == 2'd2) begin
      if (addr[15:0] == 16'hAAAA)      rd_data = 16'h5555;
      else if (addr[15:0] == 16'h5555) rd_data = cc_fault ? 16'hFFFF : 16'hAAAA;
      else                             rd_data = 16'hFFFF;
    end else if (oe_lvl == 2'd0) begin
      rd_data = mem[addr[3:0]];
      if (vcc_sel == 2'd1 && int'(addr) == bad_rd) rd_data = rd_data ^ 16'h0001;
    end else rd_data = 16'hFFFF;
  end

  always @(negedge clk) begin
    if (div == DIV-1) begin div <= 0; us_tick <= 1'b1; end
    else begin div <= div + 1; us_tick <= 1'b0; end
  end

  always @(posedge clk) if (us_tick) tick_total = tick_total + 1;

  always @(negedge clk) begin
    bit pon;
    pon = !ce_n && oe_lvl == 2'd1 && vpp_sel == 2'd3;
    if (pon && !pulse_prev) begin
      pulse_start = tick_total; pulse_addr = int'(addr);
      if (wr_data != word_of(int'(addr))) wd_err++;
    end
    if (!pon && pulse_prev) begin
      if (tick_total - pulse_start != PULSE) width_err++;
      if (!seen_vf && pulse_addr != total_pulses) order_err++;
      pcnt[pulse_addr]++;
      total_pulses++;
      if (pcnt[pulse_addr] >= need_of(pulse_addr)) mem[pulse_addr] = word_of(pulse_addr);
    end
    pulse_prev = pon;
    if (vpp_sel == 2'd3 && ce_n && oe_lvl == 2'd0 && !seen_vf) begin
      seen_vf = 1; pulses_before_vf = total_pulses;
    end
    if (vcc_sel == 2'd1 && vpp_sel == 2'd1 && !ce_n && oe_lvl == 2'd0) rd3_seen = 1;
    if (oe_lvl == 2'd2 && !ce_n && vcc_sel == 2'd2 && vpp_sel == 2'd2) begin
      if (addr == 21'h0AAAA) cc_a_seen = 1;
      if (addr == 21'h05555 && cc_a_seen) cc_b_seen = 1;
    end
    if (vcc_sel != vcc_prev || vpp_sel != vpp_prev) sup_tick = tick_total;
    if (ce_prev && !ce_n && tick_total - sup_tick < SETTLE) settle_err++;
    if (vpp_sel == 2'd3 && addr != addr_prev && !(ce_n && oe_lvl == 2'd1)) inh_err++;
    vcc_prev = vcc_sel; vpp_prev = vpp_sel; ce_prev = ce_n; addr_prev = addr;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic reset_model();
    for (int i = 0; i < N; i++) begin mem[i] = 16'hFFFF; pcnt[i] = 0; end
    weak_a = -1; weak_n = 1; bad_rd = -1; cc_fault = 0;
    total_pulses = 0; pulses_before_vf = -1; width_err = 0; wd_err = 0;
    order_err = 0; settle_err = 0; inh_err = 0;
    seen_vf = 0; rd3_seen = 0; cc_a_seen = 0; cc_b_seen = 0;
  endtask

  bit cleared;
  task automatic run_seq(input int mid_start);
    int cyc;
    cyc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cleared = !done;
    while (!done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == mid_start);
    end
    start = 1'b0;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
    end
  endtask

  function automatic int pcnt_bad();
    int b;
    b = 0;
    for (int i = 0; i < N; i++) if (pcnt[i] != need_of(i)) b++;
    return b;
  endfunction

  initial begin
    #1900000;
    checks++; errs++;
    $display("FAIL global watchdog R8 actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    reset_model();
    vcc_prev = 2'd0; vpp_prev = 2'd0; ce_prev = 1'b1; addr_prev = '0;
    repeat (4) @(negedge clk);
    chk(!done && !pass && vcc_sel == 0 && vpp_sel == 0 && ce_n && oe_lvl == 1 && !data_drive,
        "R1 reset outputs", {done, pass, vcc_sel, vpp_sel}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && ce_n && vcc_sel == 0 && oe_lvl == 1, "R1 after reset", done, 0);

    // Good run: word 3 needs 2 pulses, word 7 needs 3
    reset_model(); weak_a = 7; weak_n = 3;
    run_seq(-1);
    chk(done && pass, "R7 good run pass", pass, 1);
    chk(cc_a_seen && cc_b_seen, "R2 contact patterns", cc_b_seen, 1);
    chk(pulses_before_vf == N, "R3 pulses before verify", pulses_before_vf, N);
    chk(order_err == 0, "R3 address order", order_err, 0);
    chk(width_err == 0, "R3 pulse width", width_err, 0);
    chk(wd_err == 0, "R3 write data", wd_err, 0);
    chk(pcnt_bad() == 0, "R6 per-word pulse count", pcnt_bad(), 0);
    chk(total_pulses == N + 3, "R6 total pulses", total_pulses, N + 3);
    chk(inh_err == 0, "R4 address change inhibit", inh_err, 0);
    chk(settle_err == 0, "R5 settle before enable", settle_err, 0);
    chk(rd3_seen, "R7 low-supply readback", rd3_seen, 1);
    repeat (60) @(negedge clk);
    chk(done && pass, "R8 result held", {done, pass}, 3);

    // Retry exhaustion on word 9
    reset_model(); weak_a = 9; weak_n = RETRY + 2;
    run_seq(-1);
    chk(cleared, "R8 start clears done", cleared, 1);
    chk(done && !pass, "R6 retry exhaustion fails", pass, 0);
    chk(pcnt[9] == RETRY + 1, "R6 pulses on failing word", pcnt[9], RETRY + 1);
    chk(!rd3_seen, "R6 no readback after fail", rd3_seen, 0);
    chk(vcc_sel == 0 && vpp_sel == 0, "R6 supplies off at end", vpp_sel, 0);

    // Contact failure: second pattern reads 0xFFFF
    reset_model(); cc_fault = 1;
    run_seq(-1);
    chk(done && !pass, "R2 contact fail", pass, 0);
    chk(total_pulses == 0, "R2 no pulse after contact fail", total_pulses, 0);

    // Word 12 reads wrong only at the 3.0 V level
    reset_model(); bad_rd = 12;
    run_seq(-1);
    chk(done && !pass, "R7 low-supply mismatch fails", pass, 0);
    chk(rd3_seen && pcnt_bad() == 0, "R7 verify completed first", pcnt_bad(), 0);

    // Start repeated mid-run is ignored
    reset_model(); weak_a = 7; weak_n = 3;
    run_seq(300);
    chk(done && pass, "R8 mid-run start ignored pass", pass, 1);
    chk(total_pulses == N + 3 && pcnt_bad() == 0, "R8 mid-run start no restart",
        total_pulses, N + 3);
    chk(inh_err == 0 && settle_err == 0, "R4 R5 second good run", inh_err + settle_err, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule